// File: doc/BRIEF.md
# AHB-style Master Burst Address Sequencer

This block sits on the master side of an AHB-style system bus and turns one command into the complete address-phase sequence of a burst. A client presents a byte start address, a beat size, a burst kind and a direction, then pulses a request strobe while the sequencer is idle. For every beat the block drives the address, the transfer-type code, the size, the burst code and the write flag. It moves to the next beat only on a cycle where the bus ready input is high.

Both incrementing and wrapping addresses are generated. A wrapping burst keeps the address bits above its window fixed and rolls only the bits inside it. The window is (beats × 2^size) bytes. An open-length incrementing burst keeps issuing beats until the client raises a stop input on an accepted beat. A pause input inserts BUSY cycles in the middle of any burst. A beat counter reports how many address phases of the current burst the bus has accepted. Arbitration, retry, split and error recovery are not handled here.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and just after it is released, the transfer type is IDLE (code 00) and the beat counter is 0.
- R2: With the type at IDLE, ready high, the strobe high and a legal size, the next cycle shows NONSEQ (code 10). On that cycle the address, size, burst code and write flag equal the command fields (write flag 1 for a write, 0 for a read).
- R3: A command whose size code (2^size bytes per beat; 0 is 8 bits and 7 is 1024 bits) is wider than the data bus parameter (32 bits by default, so any code above 2) is ignored, and the type stays IDLE.
- R4: On a cycle with ready low, the next cycle shows the same address, type, size, burst code, write flag and beat count.
- R5: Burst codes are SINGLE=000, INCR=001, WRAP4=010, INCR4=011, WRAP8=100, INCR8=101, WRAP16=110 and INCR16=111. A fixed burst issues exactly 1, 4, 8 or 16 beats, the first NONSEQ and the rest SEQ (code 11), and the type then returns to IDLE.
- R6: In an incrementing burst, each beat's address is the previous beat's address plus 2^size.
- R7: In a wrapping burst, each beat's address is the previous beat's address plus 2^size, taken modulo a window of (beats × 2^size) bytes. The bits above the window stay unchanged.
- R8: An INCR (001) burst ends after the accepted beat on which stop is high, or on a BUSY cycle with ready high and stop high. The type then goes to IDLE even if pause is also high. Stop has no effect on fixed bursts.
- R9: When a beat is accepted with pause high and the burst is not over, the type becomes BUSY (code 01) and shows the next beat's address. It stays BUSY while pause is high. When pause drops with ready high, the type becomes SEQ at the same address.
- R10: The beat counter is cleared when a command is accepted. It rises by one for each NONSEQ or SEQ cycle with ready high, and BUSY cycles leave it unchanged.
- R11: A strobe raised while a burst is in progress has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request strobe |
| cmd_addr | input | AW | Start byte address |
| cmd_size | input | 3 | Beat size code |
| cmd_burst | input | 3 | Burst kind code |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_pause | input | 1 | Insert BUSY between beats |
| cmd_stop | input | 1 | End an open-length incrementing burst |
| bus_ready | input | 1 | Bus ready; the outputs advance only when it is high |
| bus_addr | output | AW | Address-phase byte address |
| bus_trans | output | 2 | Transfer type code |
| bus_size | output | 3 | Size code of the burst |
| bus_burst | output | 3 | Burst code of the burst |
| bus_write | output | 1 | Direction of the burst |
| beat_cnt | output | CW | Accepted beats of the current burst |

## Verification
In an open-length burst, ending the burst and inserting a pause can fall on the same accepted beat. The bench raises stop and pause together on an accepted SEQ beat, and raises stop again during a BUSY cycle. In both cases it judges that the type goes straight to IDLE with the beat count frozen. A second overlap is ready low arriving while a new strobe is presented mid-burst. The bench checks that the stalled beat holds and that the burst then continues at its own next address.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
   typedef enum logic [1:0] {
      XF_IDLE = 2'b00,
      XF_BUSY = 2'b01,
      XF_NSEQ = 2'b10,
      XF_SEQ  = 2'b11
   } xfer_e;

   typedef enum logic [2:0] {
      BK_ONE    = 3'b000,
      BK_OPEN   = 3'b001,
      BK_WRAP4  = 3'b010,
      BK_INC4   = 3'b011,
      BK_WRAP8  = 3'b100,
      BK_INC8   = 3'b101,
      BK_WRAP16 = 3'b110,
      BK_INC16  = 3'b111
   } burst_e;

   localparam int LEN_W = 4;   // holds beats-1 of the longest fixed burst
endpackage

// File: rtl/bseq_len.sv
module bseq_len
   import bseq_pkg::*;
(
   input  logic [2:0]       burst,
   output logic [LEN_W-1:0] last_idx,
   output logic             open_len,
   output logic             wrap,
   output logic [2:0]       len_log2
);
   always_comb begin
      case (burst)
         BK_WRAP4,  BK_INC4:  len_log2 = 3'd2;
         BK_WRAP8,  BK_INC8:  len_log2 = 3'd3;
         BK_WRAP16, BK_INC16: len_log2 = 3'd4;
         default:             len_log2 = 3'd0;
      endcase
      last_idx = LEN_W'((5'd1 << len_log2) - 5'd1);
      open_len = (burst == BK_OPEN);
      wrap     = (burst != BK_ONE) && !burst[0];
   end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr,
   input  logic [2:0]    size,
   input  logic          wrap,
   input  logic [2:0]    len_log2,
   output logic [AW-1:0] nxt,
   output logic [3:0]    win_exp
);
   logic [AW-1:0] step;
   logic [AW-1:0] inc;

   assign step    = AW'(1) << size;
   assign inc     = addr + step;
   assign win_exp = {1'b0, size} + {1'b0, len_log2};

   for (genvar i = 0; i < AW; i++) begin : g_bit
      logic frozen;
      assign frozen = wrap && (32'(i) >= 32'(win_exp));
      assign nxt[i] = frozen ? addr[i] : inc[i];
   end
endmodule

// File: rtl/bseq_beats.sv
module bseq_beats #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          bump,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (bump)  cnt <= cnt + 1'b1;
   end

   p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !clear) |=> cnt == $past(cnt) + 1'b1);
   p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt == '0);
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
   import bseq_pkg::*;
#(
   parameter int AW       = 32,
   parameter int MAX_SIZE = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [AW-1:0] cmd_addr,
   input  logic [2:0]    cmd_size,
   input  logic [2:0]    cmd_burst,
   input  logic          cmd_write,
   input  logic          cmd_pause,
   input  logic          cmd_stop,
   input  logic          bus_ready,
   output logic [1:0]    trans_o,
   output logic [AW-1:0] addr_o,
   output logic [2:0]    size_o,
   output logic [2:0]    burst_o,
   output logic          write_o,
   output logic          accept_o,
   output logic          beat_done_o
);
   xfer_e            trans_q;
   logic [AW-1:0]    addr_q;
   logic [2:0]       size_q, burst_q, lg_q;
   logic             write_q, open_q, wrap_q;
   logic [LEN_W-1:0] left_q;

   logic [LEN_W-1:0] c_last;
   logic             c_open, c_wrap;
   logic [2:0]       c_lg;
   logic [AW-1:0]    nxt_addr;
   logic [3:0]       win_exp;
   logic             size_ok, in_beat, final_beat;

   bseq_len u_len (
      .burst    (cmd_burst),
      .last_idx (c_last),
      .open_len (c_open),
      .wrap     (c_wrap),
      .len_log2 (c_lg)
   );

   bseq_addr_gen #(.AW(AW)) u_ag (
      .addr     (addr_q),
      .size     (size_q),
      .wrap     (wrap_q),
      .len_log2 (lg_q),
      .nxt      (nxt_addr),
      .win_exp  (win_exp)
   );

   assign size_ok     = (cmd_size <= 3'(MAX_SIZE));
   assign in_beat     = (trans_q == XF_NSEQ) || (trans_q == XF_SEQ);
   assign final_beat  = open_q ? cmd_stop : (left_q == '0);
   assign accept_o    = bus_ready && (trans_q == XF_IDLE) && cmd_valid && size_ok;
   assign beat_done_o = bus_ready && in_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trans_q <= XF_IDLE;
         addr_q  <= '0;
         size_q  <= '0;
         burst_q <= '0;
         lg_q    <= '0;
         write_q <= 1'b0;
         open_q  <= 1'b0;
         wrap_q  <= 1'b0;
         left_q  <= '0;
      end else if (bus_ready) begin
         case (trans_q)
            XF_IDLE: begin
               if (accept_o) begin
                  trans_q <= XF_NSEQ;
                  addr_q  <= cmd_addr;
                  size_q  <= cmd_size;
                  burst_q <= cmd_burst;
                  write_q <= cmd_write;
                  open_q  <= c_open;
                  wrap_q  <= c_wrap;
                  lg_q    <= c_lg;
                  left_q  <= c_last;
               end
            end
            XF_NSEQ, XF_SEQ: begin
               if (final_beat) begin
                  trans_q <= XF_IDLE;
               end else begin
                  addr_q  <= nxt_addr;
                  trans_q <= cmd_pause ? XF_BUSY : XF_SEQ;
                  if (!open_q) left_q <= left_q - 1'b1;
               end
            end
            XF_BUSY: begin
               if (open_q && cmd_stop) trans_q <= XF_IDLE;
               else if (!cmd_pause)    trans_q <= XF_SEQ;
            end
         endcase
      end
   end

   assign trans_o = trans_q;
   assign addr_o  = addr_q;
   assign size_o  = size_q;
   assign burst_o = burst_q;
   assign write_o = write_q;

   p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ready |=> $stable(trans_q) && $stable(addr_q) && $stable(size_q)
                     && $stable(burst_q) && $stable(write_q));
   p_no_seq_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trans_q == XF_IDLE) |=> (trans_q == XF_IDLE) || (trans_q == XF_NSEQ));
   p_incr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_done_o && !final_beat && !wrap_q)
      |=> addr_q == $past(addr_q) + (AW'(1) << $past(size_q)));
   p_wrap_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_done_o && !final_beat && wrap_q)
      |=> (addr_q >> $past(win_exp)) == ($past(addr_q) >> $past(win_exp)));
   p_size_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trans_q != XF_IDLE) |-> (size_q <= 3'(MAX_SIZE)));
   p_busy_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((trans_q == XF_BUSY) && bus_ready && !cmd_pause && !(open_q && cmd_stop))
      |=> (trans_q == XF_SEQ) && $stable(addr_q));
   p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_done_o && open_q && cmd_stop) |=> trans_q == XF_IDLE);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [AW-1:0] cmd_addr,
   input  logic [2:0]    cmd_size,
   input  logic [2:0]    cmd_burst,
   input  logic          cmd_write,
   input  logic          cmd_pause,
   input  logic          cmd_stop,
   input  logic          bus_ready,
   output logic [AW-1:0] bus_addr,
   output logic [1:0]    bus_trans,
   output logic [2:0]    bus_size,
   output logic [2:0]    bus_burst,
   output logic          bus_write,
   output logic [CW-1:0] beat_cnt
);
   localparam int MAX_SIZE = $clog2(DW / 8);

   logic accept, beat_done;

   initial begin
      a_param_dw: assert (DW >= 8 && DW <= 1024 && (DW & (DW - 1)) == 0)
         else $error("DW must be a power of two from 8 to 1024");
      a_param_aw: assert (AW >= 12 && CW >= 5)
         else $error("AW or CW too small");
   end

   bseq_ctrl #(.AW(AW), .MAX_SIZE(MAX_SIZE)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_addr    (cmd_addr),
      .cmd_size    (cmd_size),
      .cmd_burst   (cmd_burst),
      .cmd_write   (cmd_write),
      .cmd_pause   (cmd_pause),
      .cmd_stop    (cmd_stop),
      .bus_ready   (bus_ready),
      .trans_o     (bus_trans),
      .addr_o      (bus_addr),
      .size_o      (bus_size),
      .burst_o     (bus_burst),
      .write_o     (bus_write),
      .accept_o    (accept),
      .beat_done_o (beat_done)
   );

   bseq_beats #(.CW(CW)) u_beats (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .bump  (beat_done),
      .cnt   (beat_cnt)
   );

   p_idle_after_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (bus_trans == 2'b00) && (beat_cnt == '0));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_pause = 1'b0, cmd_stop = 1'b0;
   logic        bus_ready = 1'b1;
   logic [31:0] cmd_addr = '0;
   logic [2:0]  cmd_size = '0, cmd_burst = '0;
   logic [31:0] bus_addr;
   logic [1:0]  bus_trans;
   logic [2:0]  bus_size, bus_burst;
   logic        bus_write;
   logic [7:0]  beat_cnt;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   burst_addr_seq u0 (.*);

   localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;
   localparam int NV = 9;
   localparam logic [31:0] V_ADDR  [NV] = '{32'h1000, 32'h2004, 32'h0038, 32'h0102,
                                            32'h0203, 32'h0334, 32'h0400, 32'h0500, 32'h0FFE};
   localparam logic [2:0]  V_SIZE  [NV] = '{3'd2, 3'd2, 3'd2, 3'd1, 3'd0, 3'd2, 3'd2, 3'd1, 3'd0};
   localparam logic [2:0]  V_BURST [NV] = '{3'd0, 3'd3, 3'd2, 3'd4, 3'd5, 3'd6, 3'd7, 3'd1, 3'd2};
   localparam logic        V_WR    [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam int          V_BEATS [NV] = '{1, 4, 4, 8, 8, 16, 16, 5, 4};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] model_next(logic [31:0] a, logic [2:0] sz, logic [2:0] bk);
      int unsigned step, win;
      logic [31:0] base;
      step = 1 << sz;
      if (bk == 3'd2 || bk == 3'd4 || bk == 3'd6) begin
         win  = step * ((bk == 3'd2) ? 4 : (bk == 3'd4) ? 8 : 16);
         base = a - (a % win);
         return base + ((a - base + step) % win);
      end
      return a + step;
   endfunction

   task automatic start(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] bk);
      cmd_addr = a; cmd_size = sz; cmd_burst = bk; cmd_write = 1'b0; cmd_valid = 1'b1;
      tick;
      cmd_valid = 1'b0;
   endtask

   initial begin
      #1;
      chk("R1 trans in reset", 32'(bus_trans), 32'(T_IDLE));
      chk("R1 count in reset", 32'(beat_cnt), 0);
      repeat (3) tick;
      rst_n = 1'b1;
      tick;
      chk("R1 trans after reset", 32'(bus_trans), 32'(T_IDLE));

      // table walk: R2 R5 R6 R7 R8 R10
      for (int v = 0; v < NV; v++) begin
         logic [31:0] a;
         cmd_addr = V_ADDR[v]; cmd_size = V_SIZE[v]; cmd_burst = V_BURST[v];
         cmd_write = V_WR[v]; cmd_valid = 1'b1;
         tick;
         cmd_valid = 1'b0;
         a = V_ADDR[v];
         for (int k = 0; k < V_BEATS[v]; k++) begin
            chk("R5 beat type", 32'(bus_trans), 32'((k == 0) ? T_NSEQ : T_SEQ));
            chk("R6/R7 beat address", bus_addr, a);
            chk("R10 count during burst", 32'(beat_cnt), 32'(k));
            if (k == 0) begin
               chk("R2 size", 32'(bus_size), 32'(V_SIZE[v]));
               chk("R2 burst", 32'(bus_burst), 32'(V_BURST[v]));
               chk("R2 write", 32'(bus_write), 32'(V_WR[v]));
            end
            if (V_BURST[v] == 3'd1 && k == V_BEATS[v] - 1) cmd_stop = 1'b1;
            tick;
            cmd_stop = 1'b0;
            a = model_next(a, V_SIZE[v], V_BURST[v]);
         end
         chk("R5 R8 idle after burst", 32'(bus_trans), 32'(T_IDLE));
         chk("R10 final count", 32'(beat_cnt), 32'(V_BEATS[v]));
      end

      // R3: oversize command ignored
      cmd_addr = 32'h10; cmd_size = 3'd3; cmd_burst = 3'd0; cmd_valid = 1'b1;
      tick; tick;
      chk("R3 oversize ignored", 32'(bus_trans), 32'(T_IDLE));
      cmd_size = 3'd2;
      tick;
      cmd_valid = 1'b0;
      chk("R3 legal size taken", 32'(bus_trans), 32'(T_NSEQ));
      tick;
      chk("R5 single ends", 32'(bus_trans), 32'(T_IDLE));

      // R4 + R11: stall and stray strobe
      start(32'h40, 3'd2, 3'd3);
      bus_ready = 1'b0; cmd_valid = 1'b1; cmd_addr = 32'h900;
      tick; tick;
      chk("R4 type held", 32'(bus_trans), 32'(T_NSEQ));
      chk("R4 address held", bus_addr, 32'h40);
      chk("R4 count held", 32'(beat_cnt), 0);
      bus_ready = 1'b1;
      tick;
      chk("R11 strobe ignored type", 32'(bus_trans), 32'(T_SEQ));
      chk("R11 strobe ignored address", bus_addr, 32'h44);
      cmd_valid = 1'b0;
      tick; tick;
      chk("R11 burst continues", bus_addr, 32'h4C);
      tick;
      chk("R11 ends idle", 32'(bus_trans), 32'(T_IDLE));
      chk("R10 count after stall", 32'(beat_cnt), 4);

      // R9: pause inserts BUSY
      start(32'h80, 3'd2, 3'd3);
      cmd_pause = 1'b1;
      tick;
      chk("R9 busy type", 32'(bus_trans), 32'(T_BUSY));
      chk("R9 busy address", bus_addr, 32'h84);
      tick;
      chk("R9 busy kept", 32'(bus_trans), 32'(T_BUSY));
      chk("R10 busy not counted", 32'(beat_cnt), 1);
      cmd_pause = 1'b0;
      tick;
      chk("R9 resume seq", 32'(bus_trans), 32'(T_SEQ));
      chk("R9 resume address", bus_addr, 32'h84);
      tick; tick; tick;
      chk("R9 burst complete", 32'(bus_trans), 32'(T_IDLE));
      chk("R10 count after pause", 32'(beat_cnt), 4);

      // R8: stop ignored on fixed burst
      start(32'hC0, 3'd2, 3'd3);
      cmd_stop = 1'b1;
      tick; tick; tick;
      chk("R8 stop ignored fixed", 32'(bus_trans), 32'(T_SEQ));
      chk("R8 stop ignored address", bus_addr, 32'hCC);
      tick;
      cmd_stop = 1'b0;
      chk("R8 fixed ends at four", 32'(beat_cnt), 4);

      // R8: stop and pause on the same accepted beat
      start(32'h100, 3'd2, 3'd1);
      tick;
      cmd_stop = 1'b1; cmd_pause = 1'b1;
      tick;
      chk("R8 stop beats pause", 32'(bus_trans), 32'(T_IDLE));
      chk("R8 count stop+pause", 32'(beat_cnt), 2);
      cmd_stop = 1'b0;

      // R8: stop during BUSY
      start(32'h200, 3'd2, 3'd1);
      tick;
      chk("R9 busy in open burst", 32'(bus_trans), 32'(T_BUSY));
      cmd_stop = 1'b1;
      tick;
      chk("R8 stop from busy", 32'(bus_trans), 32'(T_IDLE));
      chk("R8 count stop from busy", 32'(beat_cnt), 1);
      cmd_stop = 1'b0; cmd_pause = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule